// File: doc/BRIEF.md
# Receive Frame Buffer with Status Trailer

This block sits between a network receiver and a receive DMA engine. The receiver streams frame data words into it, followed by one end marker. The end marker carries an error flag, a status/statistics word and a capture timestamp. The block writes the frame into an on-chip circular word memory behind a tentative write pointer. On a clean end marker it appends a trailer of one or two words: the status word, and the timestamp when capture is enabled. It then commits the frame. A frame that ends in error is rewound. Only a one-word status entry is kept for it, and the space its data used is free for the next frame at once.

The read side works in full store-and-forward order. The DMA engine sees a frame only after that frame's trailer has been committed. It reads the data words and then the trailer over a valid/ready stream. Status entries of rejected frames never reach the DMA stream; the read side consumes them on its own. Every status word, good or bad, is reported on a status update port in buffer order, so statistics counters can be kept. When a data word arrives with too little room left for it plus a full trailer, the whole frame is dropped and a one-cycle overflow interrupt is raised.

Top module: `rx_pkt_buffer`

## Requirements
- R1: After reset, `frame_avail`, `dma_valid`, `stat_valid` and `ovf_irq` are all low.
- R2: A good frame appears on the DMA stream as its data words in arrival order with `dma_kind` = 0 and `dma_last` = 0, followed by its status word with `dma_kind` = 1. `dma_last` is never set on a data word. Data beats (`rx_valid`) and the end marker (`rx_end`) never fall in the same cycle.
- R3: If `ts_en` is high at the end marker of a good frame, a timestamp word (`dma_kind` = 2, `dma_last` = 1) follows the status word, and the status word has `dma_last` = 0. If `ts_en` is low, the status word carries `dma_last` = 1.
- R4: A frame whose end marker has `rx_err` high never shows any word on the DMA stream. Its status is reported on the status port with `stat_good` = 0, in buffer order. Its data space is reusable at once, and it occupies only one buffer word.
- R5: For each good frame, `stat_valid` pulses with `stat_good` = 1 and the frame's status word in the cycle after the DMA accepts that status word.
- R6: While a frame is still being received, no word of it is visible on the DMA side. `frame_avail` rises in the cycle after its end marker.
- R7: `frame_avail` is high exactly while at least one committed good frame has unread words. It falls after the final trailer word of the last such frame is accepted. `dma_valid` implies `frame_avail`.
- R8: A data beat that finds fewer than three free words (buffer depth counts data and trailers) drops the whole frame. `ovf_irq` pulses for one cycle in the next cycle. The frame's remaining beats and end marker are ignored, it leaves no entry, and occupancy never exceeds the depth.
- R9: Frames arriving after an overflow are accepted normally once space exists.
- R10: While `dma_valid` is high and `dma_ready` is low, `dma_valid`, `dma_data`, `dma_kind` and `dma_last` hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ts_en | input | 1 | Timestamp capture enable, sampled at the end marker |
| rx_valid | input | 1 | Receive data beat strobe |
| rx_data | input | DW | Receive data word |
| rx_end | input | 1 | End-of-frame marker (no data on this cycle) |
| rx_err | input | 1 | Frame has an error, valid with `rx_end` |
| rx_stat | input | DW | Status/statistics word, valid with `rx_end` |
| rx_ts | input | DW | Capture timestamp, valid with `rx_end` |
| frame_avail | output | 1 | At least one complete good frame is waiting |
| dma_valid | output | 1 | DMA stream word valid |
| dma_ready | input | 1 | DMA accepts the current word |
| dma_data | output | DW | DMA stream word |
| dma_kind | output | 2 | 0 data, 1 status, 2 timestamp |
| dma_last | output | 1 | Final word of the frame |
| stat_valid | output | 1 | Status update strobe |
| stat_good | output | 1 | Status belongs to a forwarded frame |
| stat_data | output | DW | Status/statistics word |
| ovf_irq | output | 1 | One-cycle receive overflow interrupt |

## Verification
Directed traffic with the reader stalled fills the memory. A long frame then overruns it mid-reception. This separates whole-frame rollback from partial forwarding, and a small frame sent afterwards shows that recovery works. A long errored frame followed by a frame that fits only if the errored frame's space was reclaimed tells immediate reclaim apart from deferred reclaim. Random traffic mixes frame lengths including zero, error and timestamp choices, and a randomly stalling reader. Against a scoreboard, this checks word order, trailer layout, status order for good and bad frames, and hold-under-stall.

// File: rtl/rxpb_pkg.sv
package rxpb_pkg;

    typedef enum logic [1:0] {
        KIND_DATA   = 2'd0,
        KIND_STAT   = 2'd1,
        KIND_TSTAMP = 2'd2,
        KIND_DROP   = 2'd3
    } word_kind_t;

    typedef struct packed {
        word_kind_t kind;
        logic       last;
    } word_tag_t;

    typedef enum logic {
        WS_ACCEPT  = 1'b0,
        WS_DISCARD = 1'b1
    } wr_state_t;

    localparam int TAG_W       = $bits(word_tag_t);
    localparam int TRAILER_MAX = 2;
    localparam int DATA_ROOM   = TRAILER_MAX + 1;

    function automatic word_tag_t make_tag(input word_kind_t k, input logic l);
        word_tag_t t;
        t.kind = k;
        t.last = l;
        return t;
    endfunction

endpackage

// File: rtl/rxpb_mem.sv
module rxpb_mem #(
    parameter int W  = 34,
    parameter int AW = 6
) (
    input  logic          clk,
    input  logic          a_en,
    input  logic [AW-1:0] a_addr,
    input  logic [W-1:0]  a_word,
    input  logic          b_en,
    input  logic [AW-1:0] b_addr,
    input  logic [W-1:0]  b_word,
    input  logic [AW-1:0] rd_addr,
    output logic [W-1:0]  rd_word
);
    localparam int DEPTH = 1 << AW;

    logic [W-1:0] cells [DEPTH];

    always_ff @(posedge clk) begin
        if (a_en) cells[a_addr] <= a_word;
        if (b_en) cells[b_addr] <= b_word;
    end

    assign rd_word = cells[rd_addr];
endmodule

// File: rtl/rxpb_wr_ctrl.sv
module rxpb_wr_ctrl
    import rxpb_pkg::*;
#(
    parameter int DW = 32,
    parameter int AW = 6
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                ts_en,
    input  logic                rx_valid,
    input  logic [DW-1:0]       rx_data,
    input  logic                rx_end,
    input  logic                rx_err,
    input  logic [DW-1:0]       rx_stat,
    input  logic [DW-1:0]       rx_ts,
    input  logic [AW:0]         rd_ptr,
    output logic                wa_en,
    output logic [AW-1:0]       wa_addr,
    output logic [TAG_W+DW-1:0] wa_word,
    output logic                wb_en,
    output logic [AW-1:0]       wb_addr,
    output logic [TAG_W+DW-1:0] wb_word,
    output logic [AW:0]         wcom_ptr,
    output logic                good_commit,
    output logic                ovf_irq
);
    localparam int PW    = AW + 1;
    localparam int DEPTH = 1 << AW;
    localparam logic [PW-1:0] DEPTH_W = PW'(DEPTH);
    localparam logic [PW-1:0] ROOM_W  = PW'(DATA_ROOM);

    wr_state_t     state_q;
    logic [PW-1:0] wtent_q, wcom_q;
    logic [PW-1:0] wtent_inc, free_t, free_c, trl_len;
    logic          ev_data, ev_good, ev_bad, ev_ovf;

    assign wtent_inc = wtent_q + PW'(1);
    assign free_t    = DEPTH_W - (wtent_q - rd_ptr);
    assign free_c    = DEPTH_W - (wcom_q - rd_ptr);
    assign trl_len   = ts_en ? PW'(2) : PW'(1);

    always_comb begin
        wa_en   = 1'b0;
        wa_addr = wtent_q[AW-1:0];
        wa_word = '0;
        wb_en   = 1'b0;
        wb_addr = wtent_inc[AW-1:0];
        wb_word = {make_tag(KIND_TSTAMP, 1'b1), rx_ts};
        ev_data = 1'b0;
        ev_good = 1'b0;
        ev_bad  = 1'b0;
        ev_ovf  = 1'b0;
        if (state_q == WS_ACCEPT) begin
            if (rx_valid) begin
                if (free_t >= ROOM_W) begin
                    ev_data = 1'b1;
                    wa_en   = 1'b1;
                    wa_word = {make_tag(KIND_DATA, 1'b0), rx_data};
                end else begin
                    ev_ovf = 1'b1;
                end
            end else if (rx_end) begin
                if (rx_err) begin
                    if (free_c >= PW'(1)) begin
                        ev_bad  = 1'b1;
                        wa_en   = 1'b1;
                        wa_addr = wcom_q[AW-1:0];
                        wa_word = {make_tag(KIND_DROP, 1'b1), rx_stat};
                    end else begin
                        ev_ovf = 1'b1;
                    end
                end else if (free_t >= trl_len) begin
                    ev_good = 1'b1;
                    wa_en   = 1'b1;
                    wa_word = {make_tag(KIND_STAT, !ts_en), rx_stat};
                    wb_en   = ts_en;
                end else begin
                    ev_ovf = 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= WS_ACCEPT;
            wtent_q <= '0;
            wcom_q  <= '0;
            ovf_irq <= 1'b0;
        end else begin
            ovf_irq <= ev_ovf;
            if (ev_data) wtent_q <= wtent_inc;
            if (ev_good) begin
                wtent_q <= wtent_q + trl_len;
                wcom_q  <= wtent_q + trl_len;
            end
            if (ev_bad) begin
                wtent_q <= wcom_q + PW'(1);
                wcom_q  <= wcom_q + PW'(1);
            end
            if (ev_ovf) begin
                wtent_q <= wcom_q;
                if (rx_valid) state_q <= WS_DISCARD;
            end
            if (state_q == WS_DISCARD && rx_end) state_q <= WS_ACCEPT;
        end
    end

    assign wcom_ptr    = wcom_q;
    assign good_commit = ev_good;
endmodule

// File: rtl/rxpb_rd_ctrl.sv
module rxpb_rd_ctrl
    import rxpb_pkg::*;
#(
    parameter int DW = 32,
    parameter int AW = 6
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [TAG_W+DW-1:0] rd_word,
    input  logic [AW:0]         wcom_ptr,
    input  logic                good_commit,
    input  logic                dma_ready,
    output logic [AW:0]         rd_ptr,
    output logic                frame_avail,
    output logic                dma_valid,
    output logic [DW-1:0]       dma_data,
    output logic [1:0]          dma_kind,
    output logic                dma_last,
    output logic                stat_valid,
    output logic                stat_good,
    output logic [DW-1:0]       stat_data
);
    localparam int PW = AW + 1;

    word_tag_t     head_tag;
    logic [DW-1:0] head_data;
    logic [PW-1:0] rd_q, frames_q;
    logic          nonempty, is_drop, take, skip, frame_done;

    assign head_tag  = word_tag_t'(rd_word[TAG_W+DW-1:DW]);
    assign head_data = rd_word[DW-1:0];
    assign nonempty  = (rd_q != wcom_ptr);
    assign is_drop   = (head_tag.kind == KIND_DROP);

    assign dma_valid  = nonempty && !is_drop;
    assign dma_data   = head_data;
    assign dma_kind   = head_tag.kind;
    assign dma_last   = head_tag.last;
    assign take       = dma_valid && dma_ready;
    assign skip       = nonempty && is_drop;
    assign frame_done = take && head_tag.last;

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_q       <= '0;
            frames_q   <= '0;
            stat_valid <= 1'b0;
            stat_good  <= 1'b0;
            stat_data  <= '0;
        end else begin
            if (take || skip) rd_q <= rd_q + PW'(1);
            case ({good_commit, frame_done})
                2'b10:   frames_q <= frames_q + PW'(1);
                2'b01:   frames_q <= frames_q - PW'(1);
                default: frames_q <= frames_q;
            endcase
            stat_valid <= skip || (take && head_tag.kind == KIND_STAT);
            if (skip || take) begin
                stat_good <= take;
                stat_data <= head_data;
            end
        end
    end

    assign rd_ptr      = rd_q;
    assign frame_avail = (frames_q != '0);
endmodule

// File: rtl/rx_pkt_buffer.sv
module rx_pkt_buffer
    import rxpb_pkg::*;
#(
    parameter int DW = 32,
    parameter int AW = 6
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          ts_en,
    input  logic          rx_valid,
    input  logic [DW-1:0] rx_data,
    input  logic          rx_end,
    input  logic          rx_err,
    input  logic [DW-1:0] rx_stat,
    input  logic [DW-1:0] rx_ts,
    output logic          frame_avail,
    output logic          dma_valid,
    input  logic          dma_ready,
    output logic [DW-1:0] dma_data,
    output logic [1:0]    dma_kind,
    output logic          dma_last,
    output logic          stat_valid,
    output logic          stat_good,
    output logic [DW-1:0] stat_data,
    output logic          ovf_irq
);
    localparam int MW = TAG_W + DW;

    logic          wa_en, wb_en, good_commit;
    logic [AW-1:0] wa_addr, wb_addr;
    logic [MW-1:0] wa_word, wb_word, rd_word;
    logic [AW:0]   rd_ptr, wcom_ptr;

    rxpb_wr_ctrl #(.DW(DW), .AW(AW)) i_wr (
        .clk(clk), .rst(rst), .ts_en(ts_en),
        .rx_valid(rx_valid), .rx_data(rx_data), .rx_end(rx_end),
        .rx_err(rx_err), .rx_stat(rx_stat), .rx_ts(rx_ts),
        .rd_ptr(rd_ptr),
        .wa_en(wa_en), .wa_addr(wa_addr), .wa_word(wa_word),
        .wb_en(wb_en), .wb_addr(wb_addr), .wb_word(wb_word),
        .wcom_ptr(wcom_ptr), .good_commit(good_commit), .ovf_irq(ovf_irq)
    );

    rxpb_mem #(.W(MW), .AW(AW)) i_mem (
        .clk(clk),
        .a_en(wa_en), .a_addr(wa_addr), .a_word(wa_word),
        .b_en(wb_en), .b_addr(wb_addr), .b_word(wb_word),
        .rd_addr(rd_ptr[AW-1:0]), .rd_word(rd_word)
    );

    rxpb_rd_ctrl #(.DW(DW), .AW(AW)) i_rd (
        .clk(clk), .rst(rst), .rd_word(rd_word), .wcom_ptr(wcom_ptr),
        .good_commit(good_commit), .dma_ready(dma_ready),
        .rd_ptr(rd_ptr), .frame_avail(frame_avail),
        .dma_valid(dma_valid), .dma_data(dma_data), .dma_kind(dma_kind),
        .dma_last(dma_last), .stat_valid(stat_valid), .stat_good(stat_good),
        .stat_data(stat_data)
    );
endmodule

// File: rtl/rxpb_chk.sv
module rxpb_chk #(
    parameter int DW = 32,
    parameter int AW = 6
) (
    input logic          clk,
    input logic          rst,
    input logic          rx_valid,
    input logic          rx_end,
    input logic          frame_avail,
    input logic          dma_valid,
    input logic          dma_ready,
    input logic [DW-1:0] dma_data,
    input logic [1:0]    dma_kind,
    input logic          dma_last,
    input logic          stat_valid,
    input logic          stat_good,
    input logic          ovf_irq,
    input logic [AW:0]   rd_ptr,
    input logic [AW:0]   wcom_ptr
);
    localparam int PW = AW + 1;
    localparam logic [PW-1:0] DEPTH_W = PW'(1 << AW);

    assert_reset_quiet_R1: assert property (@(posedge clk)
        $fell(rst) |-> !frame_avail && !dma_valid && !stat_valid && !ovf_irq);

    assert_beat_end_excl_R2: assert property (@(posedge clk) disable iff (rst)
        !(rx_valid && rx_end));

    assert_last_on_trailer_R2: assert property (@(posedge clk) disable iff (rst)
        dma_valid && dma_last |-> dma_kind != 2'd0);

    assert_good_stat_follows_R5: assert property (@(posedge clk) disable iff (rst)
        stat_valid && stat_good |-> $past(dma_valid && dma_ready && dma_kind == 2'd1));

    assert_valid_needs_frame_R7: assert property (@(posedge clk) disable iff (rst)
        dma_valid |-> frame_avail);

    assert_no_overfill_R8: assert property (@(posedge clk) disable iff (rst)
        (wcom_ptr - rd_ptr) <= DEPTH_W);

    assert_hold_under_stall_R10: assert property (@(posedge clk) disable iff (rst)
        dma_valid && !dma_ready |=> dma_valid && $stable(dma_data)
                                    && $stable(dma_kind) && $stable(dma_last));
endmodule

bind rx_pkt_buffer rxpb_chk #(.DW(DW), .AW(AW)) i_chk (
    .clk(clk), .rst(rst), .rx_valid(rx_valid), .rx_end(rx_end),
    .frame_avail(frame_avail), .dma_valid(dma_valid), .dma_ready(dma_ready),
    .dma_data(dma_data), .dma_kind(dma_kind), .dma_last(dma_last),
    .stat_valid(stat_valid), .stat_good(stat_good), .ovf_irq(ovf_irq),
    .rd_ptr(rd_ptr), .wcom_ptr(wcom_ptr)
);

// File: tb/test_rx_pkt_buffer.sv
module test_rx_pkt_buffer;
    localparam int CLK_PERIOD = 10;
    localparam int DW = 32;
    localparam int AW = 6;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic ts_en = 1'b0, rx_valid = 1'b0, rx_end = 1'b0, rx_err = 1'b0;
    logic [DW-1:0] rx_data = '0, rx_stat = '0, rx_ts = '0;
    logic dma_ready = 1'b0;
    logic frame_avail, dma_valid, dma_last, stat_valid, stat_good, ovf_irq;
    logic [DW-1:0] dma_data, stat_data;
    logic [1:0] dma_kind;

    rx_pkt_buffer #(.DW(DW), .AW(AW)) i_rx_pkt_buffer (
        .clk(clk), .rst(rst), .ts_en(ts_en), .rx_valid(rx_valid), .rx_data(rx_data),
        .rx_end(rx_end), .rx_err(rx_err), .rx_stat(rx_stat), .rx_ts(rx_ts),
        .frame_avail(frame_avail), .dma_valid(dma_valid), .dma_ready(dma_ready),
        .dma_data(dma_data), .dma_kind(dma_kind), .dma_last(dma_last),
        .stat_valid(stat_valid), .stat_good(stat_good), .stat_data(stat_data),
        .ovf_irq(ovf_irq)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int checks = 0, errors = 0, ovf_cnt = 0, cons_mode = 0;
    bit prod_idle = 1'b1;
    logic [34:0] exp_dma[$];
    logic [32:0] exp_stat[$];

    task automatic check(input bit ok, input string req, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic logic [34:0] dword(input logic [1:0] k, input logic l, input logic [31:0] d);
        return {k, l, d};
    endfunction

    // consumer, status and interrupt monitor
    initial begin
        bit hold_pend = 1'b0, avail_pend = 1'b0, rdy;
        logic [34:0] hold_w, e;
        logic [32:0] s;
        forever begin
            @(negedge clk);
            if (hold_pend) begin
                check(dma_valid && {dma_kind, dma_last, dma_data} == hold_w, "R10", "stalled word",
                      {dma_valid, dma_kind, dma_last, dma_data}, {1'b1, hold_w});
                hold_pend = 1'b0;
            end
            if (avail_pend && prod_idle)
                check(frame_avail == (exp_dma.size() != 0), "R7", "frame_avail after last",
                      frame_avail, exp_dma.size() != 0);
            avail_pend = 1'b0;
            if (stat_valid) begin
                if (exp_stat.size() == 0) check(1'b0, "R5", "unexpected status", stat_data, 0);
                else begin
                    s = exp_stat.pop_front();
                    check({stat_good, stat_data} == s, s[32] ? "R5" : "R4", "status port",
                          {stat_good, stat_data}, s);
                end
            end
            if (ovf_irq) ovf_cnt++;
            rdy = (cons_mode == 2) || (cons_mode == 1 && $urandom_range(0, 1) == 1);
            dma_ready = rdy;
            if (dma_valid && rdy) begin
                if (exp_dma.size() == 0) check(1'b0, "R4", "unexpected dma word", dma_data, 0);
                else begin
                    e = exp_dma.pop_front();
                    check({dma_kind, dma_last, dma_data} == e, e[34:33] == 2'd2 ? "R3" : "R2",
                          "dma word", {dma_kind, dma_last, dma_data}, e);
                end
                if (dma_last) avail_pend = 1'b1;
            end else if (dma_valid) begin
                hold_pend = 1'b1;
                hold_w = {dma_kind, dma_last, dma_data};
            end
        end
    end

    task automatic send_frame(input int n, input bit err, input bit ts, input bit keep, input int probe);
        logic [31:0] d, st, tv;
        prod_idle = 1'b0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (i == probe)
                check(!frame_avail && !dma_valid, "R6", "visible while receiving",
                      {frame_avail, dma_valid}, 0);
            d = $urandom;
            rx_valid = 1'b1;
            rx_data = d;
            if (keep && !err) exp_dma.push_back(dword(2'd0, 1'b0, d));
        end
        @(negedge clk);
        rx_valid = 1'b0;
        st = $urandom;
        tv = $urandom;
        rx_end = 1'b1; rx_err = err; rx_stat = st; rx_ts = tv; ts_en = ts;
        if (keep) begin
            if (err) exp_stat.push_back({1'b0, st});
            else begin
                exp_dma.push_back(dword(2'd1, !ts, st));
                if (ts) exp_dma.push_back(dword(2'd2, 1'b1, tv));
                exp_stat.push_back({1'b1, st});
            end
        end
        @(negedge clk);
        rx_end = 1'b0;
        rx_err = 1'b0;
        prod_idle = 1'b1;
    endtask

    task automatic drain(input string req);
        int n = 0;
        while ((exp_dma.size() != 0 || exp_stat.size() != 0) && n < 3000) begin
            @(negedge clk);
            n++;
        end
        repeat (3) @(negedge clk);
        check(exp_dma.size() == 0 && exp_stat.size() == 0, req, "all expected words drained",
              exp_dma.size() + exp_stat.size(), 0);
        check(!frame_avail, "R7", "frame_avail after drain", frame_avail, 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        int budget = 0;
        void'($urandom(32'd11));
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check(!frame_avail && !dma_valid && !stat_valid && !ovf_irq, "R1", "reset outputs",
              {frame_avail, dma_valid, stat_valid, ovf_irq}, 0);

        // directed: fill, overflow mid-frame, recover, reclaim after error
        cons_mode = 0;
        send_frame(40, 1'b0, 1'b0, 1'b1, 20);
        check(frame_avail, "R6", "frame_avail after end marker", frame_avail, 1);
        send_frame(30, 1'b0, 1'b0, 1'b0, -1);
        check(ovf_cnt == 1, "R8", "overflow pulses", ovf_cnt, 1);
        send_frame(5, 1'b0, 1'b1, 1'b1, -1);
        check(ovf_cnt == 1, "R9", "no overflow on later frame", ovf_cnt, 1);
        send_frame(14, 1'b1, 1'b0, 1'b1, -1);
        send_frame(12, 1'b0, 1'b0, 1'b1, -1);
        check(ovf_cnt == 1, "R4", "errored frame space reclaimed", ovf_cnt, 1);
        cons_mode = 2;
        drain("R9");

        // random traffic with a stalling reader
        cons_mode = 1;
        for (int f = 0; f < 80; f++) begin
            int len = $urandom_range(0, 8);
            bit err = ($urandom_range(0, 4) == 0);
            bit ts = $urandom_range(0, 1);
            if (budget + len + 3 > 40) begin
                drain("R2");
                budget = 0;
            end
            budget += err ? 1 : len + 1 + ts;
            send_frame(len, err, ts, 1'b1, -1);
            repeat ($urandom_range(0, 3)) @(negedge clk);
        end
        drain("R2");
        check(ovf_cnt == 1, "R8", "no overflow in random phase", ovf_cnt, 1);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule